// File: doc/BRIEF.md
# Posted-Write Watchdog and Slave-Error Latch

This block sits on the write path between an APB master and its downstream endpoints. While a write is in its access phase and the endpoint holds PREADY low, a cycle counter runs; when the count reaches a programmable limit, the block gives up on the endpoint. It completes the transfer toward the master itself, with a slave error, and records a timeout cause. A limit of zero turns the watchdog off. Reads pass through untimed. Address, write data, select and enable go to the endpoint unchanged.

Next to the watchdog is a sticky latch for five slave-error causes:

| Bit | Cause |
|-----|-------|
| 0 | Watchdog timeout |
| 1 | Endpoint PSLVERR on a write |
| 2 to 4 | External error reports `extErr[0..2]` |

Each cause has a mask bit. Each cause also emits a one-cycle trigger toward an outside interrupt aggregator. A level interrupt is raised while any unmasked cause is latched. The address of the first failing write is kept. A small register port reads the latch, and both the status and the captured address can be set to clear when read.

Top module: `pwTimeoutLatch`

## Requirements
- R1: The limit register sits at offset 0x10, is 32 bits wide, reads back what was written, and resets to 0x2000.
- R2: With a limit L of 1 or more, a write whose endpoint keeps PREADY low is completed toward the master on its L-th stalled access cycle. In that cycle `mPready`=1 and `mPslverr`=1, and cause bit 0 is latched.
- R3: A limit of 0 disables the watchdog. A stalled write then waits for the endpoint for any length of time, and cause bit 0 is not set.
- R4: The counter starts again from zero for every new write. Read transfers are never timed.
- R5: Status at offset 0x8 latches cause bits as listed above. Bits are sticky, and they are set whatever the mask holds.
- R6: Mask at offset 0x0 resets to 0, and a 1 suppresses that cause. `irq` is high exactly while the status ANDed with the inverted mask is nonzero.
- R7: `trigOut[i]` is high for one cycle, in the cycle after the event of cause i, regardless of the mask.
- R8: The error address register at offset 0xC loads the failing address (`mPaddr` for bits 0 and 1, `extErrAddr` for bits 2 to 4, lowest bit first) only when no unmasked cause is pending. The first failing address is therefore kept.
- R9: In the clear-on-read control at offset 0x4, bit 0 makes a status read clear status and bit 1 makes an address read clear the address. Both reset to 1. The read returns the value from before the clear.
- R10: Writes to status and to the error address have no effect.
- R11: When no timeout occurs, `mPready` and `mPslverr` follow the endpoint, and an endpoint slave error on a write sets cause bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mPsel | input | 1 | Master select |
| mPenable | input | 1 | Master enable |
| mPwrite | input | 1 | Master write flag |
| mPaddr | input | 32 | Master address |
| mPwdata | input | 32 | Master write data |
| mPrdata | output | 32 | Read data to master |
| mPready | output | 1 | Ready to master (endpoint or abort) |
| mPslverr | output | 1 | Slave error to master |
| sPsel | output | 1 | Endpoint select |
| sPenable | output | 1 | Endpoint enable |
| sPwrite | output | 1 | Endpoint write flag |
| sPaddr | output | 32 | Endpoint address |
| sPwdata | output | 32 | Endpoint write data |
| sPrdata | input | 32 | Endpoint read data |
| sPready | input | 1 | Endpoint ready |
| sPslverr | input | 1 | Endpoint slave error |
| extErr | input | 3 | External slave-error pulses, causes 2 to 4 |
| extErrAddr | input | 32 | Address that goes with `extErr` |
| csrWrEn | input | 1 | Register write strobe |
| csrRdEn | input | 1 | Register read strobe |
| csrAddr | input | 5 | Register byte offset |
| csrWdata | input | 32 | Register write data |
| csrRdata | output | 32 | Register read data, valid in the read cycle |
| trigOut | output | 5 | One-cycle per-cause triggers |
| irq | output | 1 | Level interrupt |

## Verification
Writes are driven in several ways: with the endpoint answering before the limit, after a long stall that reaches it, with the watchdog off, with a limit of one, and at the reset default of 8192. This separates an abort on the exact stalled cycle from an abort one cycle early or late, and from a pass-through. Stalled reads and back-to-back short writes show that reads are ignored and that the count restarts. Error pulses with the mask and the clear-on-read bits set different ways show the sticky status, the first-address capture and the independence of the two clear-on-read bits. A behavioural model compares the master handshake, the interrupt, the triggers and the read data on every cycle.

// File: rtl/pwTimeoutPkg.sv
package pwTimeoutPkg;
  localparam int NUM_CAUSE = 5;
  localparam int NUM_EXT   = NUM_CAUSE - 2;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int CSR_AW    = 5;
  localparam int COR_W     = 2;

  localparam logic [CSR_AW-1:0] OFS_MASK   = 5'h00;
  localparam logic [CSR_AW-1:0] OFS_COR    = 5'h04;
  localparam logic [CSR_AW-1:0] OFS_STATUS = 5'h08;
  localparam logic [CSR_AW-1:0] OFS_ADDR   = 5'h0C;
  localparam logic [CSR_AW-1:0] OFS_LIMIT  = 5'h10;

  // strobes from control to the latch datapath
  typedef struct packed {
    logic                 wrMask;
    logic                 wrCor;
    logic                 wrLimit;
    logic                 clrStatus;
    logic                 clrAddr;
    logic                 capAddr;
    logic [NUM_CAUSE-1:0] hit;
    logic [ADDR_W-1:0]    hitAddr;
  } latchStrobeT;
endpackage

// File: rtl/pwTimeoutCtrl.sv
module pwTimeoutCtrl
  import pwTimeoutPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mPsel,
  input  logic                 mPenable,
  input  logic                 mPwrite,
  input  logic [ADDR_W-1:0]    mPaddr,
  input  logic                 sPready,
  input  logic                 sPslverr,
  input  logic [NUM_EXT-1:0]   extErr,
  input  logic [ADDR_W-1:0]    extErrAddr,
  input  logic                 csrWrEn,
  input  logic                 csrRdEn,
  input  logic [CSR_AW-1:0]    csrAddr,
  input  logic [NUM_CAUSE-1:0] statusQ,
  input  logic [NUM_CAUSE-1:0] maskQ,
  input  logic [COR_W-1:0]     corQ,
  input  logic [DATA_W-1:0]    limitQ,
  output logic                 mPready,
  output logic                 mPslverr,
  output latchStrobeT          strobe
);
  logic [DATA_W-1:0]    cntQ;
  logic                 accW, stallNow, limitOn, timeoutNow, epErr;
  logic [NUM_CAUSE-1:0] hit, pendEff;
  logic [ADDR_W-1:0]    causeAddr [NUM_CAUSE];
  logic                 clrStatus;

  assign accW       = mPsel & mPenable & mPwrite;
  assign stallNow   = accW & ~sPready;
  assign limitOn    = |limitQ;
  assign timeoutNow = stallNow & limitOn & (cntQ == limitQ - DATA_W'(1));
  assign epErr      = accW & sPready & sPslverr;

  // stalled access cycles seen so far; any other cycle restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       cntQ <= '0;
    else if (stallNow && !timeoutNow) cntQ <= (&cntQ) ? cntQ : cntQ + DATA_W'(1);
    else                             cntQ <= '0;
  end

  assign mPready  = sPready | timeoutNow;
  assign mPslverr = timeoutNow | sPslverr;

  assign hit = {extErr, epErr, timeoutNow};

  assign causeAddr[0] = mPaddr;
  assign causeAddr[1] = mPaddr;
  for (genvar g = 2; g < NUM_CAUSE; g++) begin : g_extAddr
    assign causeAddr[g] = extErrAddr;
  end

  assign clrStatus = csrRdEn && (csrAddr == OFS_STATUS) && corQ[0];
  assign pendEff   = clrStatus ? '0 : (statusQ & ~maskQ);

  always_comb begin
    strobe           = '0;
    strobe.wrMask    = csrWrEn && (csrAddr == OFS_MASK);
    strobe.wrCor     = csrWrEn && (csrAddr == OFS_COR);
    strobe.wrLimit   = csrWrEn && (csrAddr == OFS_LIMIT);
    strobe.clrStatus = clrStatus;
    strobe.clrAddr   = csrRdEn && (csrAddr == OFS_ADDR) && corQ[1];
    strobe.hit       = hit;
    strobe.capAddr   = (|hit) && (pendEff == '0);
    for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
      if (hit[i]) strobe.hitAddr = causeAddr[i];
    end
  end
endmodule

// File: rtl/pwErrLatch.sv
module pwErrLatch
  import pwTimeoutPkg::*;
#(
  parameter logic [DATA_W-1:0] LIMIT_RST = 32'h2000,
  parameter logic [COR_W-1:0]  COR_RST   = 2'b11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  latchStrobeT          strobe,
  input  logic                 csrRdEn,
  input  logic [CSR_AW-1:0]    csrAddr,
  input  logic [DATA_W-1:0]    csrWdata,
  output logic [NUM_CAUSE-1:0] statusQ,
  output logic [NUM_CAUSE-1:0] maskQ,
  output logic [COR_W-1:0]     corQ,
  output logic [DATA_W-1:0]    limitQ,
  output logic [NUM_CAUSE-1:0] trigOut,
  output logic                 irq,
  output logic [DATA_W-1:0]    csrRdata
);
  logic [ADDR_W-1:0] errAddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ    <= '0;
      corQ     <= COR_RST;
      limitQ   <= LIMIT_RST;
      statusQ  <= '0;
      errAddrQ <= '0;
      trigOut  <= '0;
    end else begin
      if (strobe.wrMask)  maskQ  <= csrWdata[NUM_CAUSE-1:0];
      if (strobe.wrCor)   corQ   <= csrWdata[COR_W-1:0];
      if (strobe.wrLimit) limitQ <= csrWdata;
      statusQ <= (strobe.clrStatus ? '0 : statusQ) | strobe.hit;
      if (strobe.capAddr)      errAddrQ <= strobe.hitAddr;
      else if (strobe.clrAddr) errAddrQ <= '0;
      trigOut <= strobe.hit;
    end
  end

  assign irq = |(statusQ & ~maskQ);

  always_comb begin
    csrRdata = '0;
    if (csrRdEn) begin
      case (csrAddr)
        OFS_MASK:   csrRdata = DATA_W'(maskQ);
        OFS_COR:    csrRdata = DATA_W'(corQ);
        OFS_STATUS: csrRdata = DATA_W'(statusQ);
        OFS_ADDR:   csrRdata = DATA_W'(errAddrQ);
        OFS_LIMIT:  csrRdata = limitQ;
        default:    csrRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pwTimeoutLatch.sv
module pwTimeoutLatch
  import pwTimeoutPkg::*;
#(
  parameter logic [DATA_W-1:0] LIMIT_RST = 32'h2000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mPsel,
  input  logic                 mPenable,
  input  logic                 mPwrite,
  input  logic [ADDR_W-1:0]    mPaddr,
  input  logic [DATA_W-1:0]    mPwdata,
  output logic [DATA_W-1:0]    mPrdata,
  output logic                 mPready,
  output logic                 mPslverr,
  output logic                 sPsel,
  output logic                 sPenable,
  output logic                 sPwrite,
  output logic [ADDR_W-1:0]    sPaddr,
  output logic [DATA_W-1:0]    sPwdata,
  input  logic [DATA_W-1:0]    sPrdata,
  input  logic                 sPready,
  input  logic                 sPslverr,
  input  logic [NUM_EXT-1:0]   extErr,
  input  logic [ADDR_W-1:0]    extErrAddr,
  input  logic                 csrWrEn,
  input  logic                 csrRdEn,
  input  logic [CSR_AW-1:0]    csrAddr,
  input  logic [DATA_W-1:0]    csrWdata,
  output logic [DATA_W-1:0]    csrRdata,
  output logic [NUM_CAUSE-1:0] trigOut,
  output logic                 irq
);
  latchStrobeT          strobe;
  logic [NUM_CAUSE-1:0] statusQ, maskQ;
  logic [COR_W-1:0]     corQ;
  logic [DATA_W-1:0]    limitQ;

  assign sPsel    = mPsel;
  assign sPenable = mPenable;
  assign sPwrite  = mPwrite;
  assign sPaddr   = mPaddr;
  assign sPwdata  = mPwdata;
  assign mPrdata  = sPrdata;

  pwTimeoutCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .mPsel(mPsel), .mPenable(mPenable), .mPwrite(mPwrite),
    .mPaddr(mPaddr), .sPready(sPready), .sPslverr(sPslverr), .extErr(extErr),
    .extErrAddr(extErrAddr), .csrWrEn(csrWrEn), .csrRdEn(csrRdEn), .csrAddr(csrAddr),
    .statusQ(statusQ), .maskQ(maskQ), .corQ(corQ), .limitQ(limitQ),
    .mPready(mPready), .mPslverr(mPslverr), .strobe(strobe)
  );

  pwErrLatch #(.LIMIT_RST(LIMIT_RST)) u_latch (
    .clk(clk), .rstN(rstN), .strobe(strobe), .csrRdEn(csrRdEn), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .statusQ(statusQ), .maskQ(maskQ), .corQ(corQ),
    .limitQ(limitQ), .trigOut(trigOut), .irq(irq), .csrRdata(csrRdata)
  );
endmodule

// File: rtl/pwTimeoutLatchChk.sv
module pwTimeoutLatchChk
  import pwTimeoutPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 mPsel,
  input logic                 mPenable,
  input logic                 mPwrite,
  input logic                 sPready,
  input logic                 mPready,
  input logic                 mPslverr,
  input logic                 csrRdEn,
  input logic [CSR_AW-1:0]    csrAddr,
  input logic [NUM_CAUSE-1:0] statusQ,
  input logic [NUM_CAUSE-1:0] maskQ,
  input logic [COR_W-1:0]     corQ,
  input logic [DATA_W-1:0]    limitQ,
  input logic [NUM_CAUSE-1:0] trigOut,
  input logic                 irq
);
  // R2: a completion the endpoint did not give is always an error
  p_abort_err_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mPready && !sPready) |-> mPslverr);

  // R3: with the limit at zero the handshake is the endpoint's own
  p_disabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    (limitQ == '0) |-> (mPready == sPready));

  // R4: reads are never cut short
  p_read_untimed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mPsel && mPenable && !mPwrite) |-> (mPready == sPready));

  // R5: status bits only drop on a clearing status read
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(csrRdEn && (csrAddr == OFS_STATUS) && corQ[0])
      |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R6: the interrupt needs an unmasked latched cause
  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((statusQ & ~maskQ) != '0));

  // R7: every trigger is matched by a latched status bit
  p_trig_status_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((trigOut & ~statusQ) == '0));
endmodule

bind pwTimeoutLatch pwTimeoutLatchChk u_chk (
  .clk(clk), .rstN(rstN), .mPsel(mPsel), .mPenable(mPenable), .mPwrite(mPwrite),
  .sPready(sPready), .mPready(mPready), .mPslverr(mPslverr), .csrRdEn(csrRdEn),
  .csrAddr(csrAddr), .statusQ(statusQ), .maskQ(maskQ), .corQ(corQ),
  .limitQ(limitQ), .trigOut(trigOut), .irq(irq)
);

// File: tb/tb_pwTimeoutLatch.sv
`timescale 1ns/1ps
module tb_pwTimeoutLatch;
  logic clk = 0, rstN = 0;
  logic mPsel = 0, mPenable = 0, mPwrite = 0;
  logic [31:0] mPaddr = 0, mPwdata = 0, mPrdata, sPaddr, sPwdata, sPrdata = 0;
  logic mPready, mPslverr, sPsel, sPenable, sPwrite;
  logic sPready = 0, sPslverr = 0;
  logic [2:0] extErr = 0;
  logic [31:0] extErrAddr = 0;
  logic csrWrEn = 0, csrRdEn = 0;
  logic [4:0] csrAddr = 0;
  logic [31:0] csrWdata = 0, csrRdata;
  logic [4:0] trigOut;
  logic irq;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pwTimeoutLatch dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [4:0]  mdStatus, mdMask, mdTrig;
  logic [1:0]  mdCor;
  logic [31:0] mdAddr, mdLimit;
  longint      mdCnt;

  always @(negedge clk) begin
    if (!rstN) begin
      mdStatus = 0; mdMask = 0; mdTrig = 0; mdCor = 2'b11;
      mdAddr = 0; mdLimit = 32'h2000; mdCnt = 0;
    end else begin
      bit accW, stall, tmo, epErr, clrS, clrA;
      logic [4:0] hits, pend;
      logic [31:0] rd, hAddr;
      accW  = mPsel && mPenable && mPwrite;
      stall = accW && !sPready;
      tmo   = stall && (mdLimit != 0) && (mdCnt == longint'(mdLimit) - 1);
      chk("R2 mPready", {31'b0, mPready}, {31'b0, sPready || tmo});
      chk("R2 mPslverr", {31'b0, mPslverr}, {31'b0, tmo ? 1'b1 : sPslverr});
      chk("R6 irq", {31'b0, irq}, {31'b0, |(mdStatus & ~mdMask)});
      chk("R7 trigOut", {27'b0, trigOut}, {27'b0, mdTrig});
      if (csrRdEn) begin
        case (csrAddr)
          5'h00: rd = {27'b0, mdMask};
          5'h04: rd = {30'b0, mdCor};
          5'h08: rd = {27'b0, mdStatus};
          5'h0C: rd = mdAddr;
          5'h10: rd = mdLimit;
          default: rd = 0;
        endcase
        chk("R9 csrRdata", csrRdata, rd);
      end
      // next state
      epErr = accW && sPready && sPslverr;
      hits  = {extErr, epErr, tmo};
      hAddr = (tmo || epErr) ? mPaddr : extErrAddr;
      clrS  = csrRdEn && csrAddr == 5'h08 && mdCor[0];
      clrA  = csrRdEn && csrAddr == 5'h0C && mdCor[1];
      pend  = clrS ? 5'b0 : (mdStatus & ~mdMask);
      if (hits != 0 && pend == 0) mdAddr = hAddr;
      else if (clrA) mdAddr = 0;
      mdStatus = (clrS ? 5'b0 : mdStatus) | hits;
      mdTrig   = hits;
      mdCnt    = (stall && !tmo) ? mdCnt + 1 : 0;
      if (csrWrEn) begin
        case (csrAddr)
          5'h00: mdMask  = csrWdata[4:0];
          5'h04: mdCor   = csrWdata[1:0];
          5'h10: mdLimit = csrWdata;
          default: ;
        endcase
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic csrWrite(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1 csrWrEn = 1; csrAddr = a; csrWdata = d;
    @(posedge clk); #1 csrWrEn = 0;
  endtask

  task automatic csrRead(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1 csrRdEn = 1; csrAddr = a;
    @(negedge clk); d = csrRdata;
    @(posedge clk); #1 csrRdEn = 0;
  endtask

  task automatic doXfer(input logic wr, input logic [31:0] a, input int stall,
                        input logic err, output int n, output logic gotErr);
    @(posedge clk); #1 mPsel = 1; mPenable = 0; mPwrite = wr; mPaddr = a;
    sPready = 0; sPslverr = 0;
    @(posedge clk); #1 mPenable = 1; n = 0;
    forever begin
      sPready = (n >= stall); sPslverr = (n >= stall) && err;
      @(negedge clk);
      if (mPready) begin gotErr = mPslverr; break; end
      @(posedge clk); #1 n++;
    end
    @(posedge clk); #1 mPsel = 0; mPenable = 0; sPready = 0; sPslverr = 0;
  endtask

  task automatic pulseExt(input logic [2:0] v, input logic [31:0] a, output logic [4:0] t);
    @(posedge clk); #1 extErr = v; extErrAddr = a;
    @(posedge clk); #1 extErr = 0;
    @(negedge clk); t = trigOut;
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic [4:0] t;
    int n;
    logic e;
    repeat (3) @(posedge clk); #1 rstN = 1;
    @(negedge clk);
    chk("R6 reset irq", {31'b0, irq}, 0);
    chk("R7 reset trig", {27'b0, trigOut}, 0);
    csrRead(5'h10, d); chk("R1 limit reset", d, 32'h2000);
    csrRead(5'h04, d); chk("R9 cor reset", d, 3);
    csrRead(5'h00, d); chk("R6 mask reset", d, 0);
    csrRead(5'h08, d); chk("R5 status reset", d, 0);

    doXfer(1, 32'h100, 3, 0, n, e);
    chk("R11 fast endpoint cycles", n, 3); chk("R11 fast endpoint err", {31'b0, e}, 0);

    csrWrite(5'h10, 5); csrRead(5'h10, d); chk("R1 limit readback", d, 5);
    doXfer(1, 32'h2A0, 100, 0, n, e);
    chk("R2 abort cycle", n, 4); chk("R2 abort err", {31'b0, e}, 1);
    @(negedge clk); chk("R6 irq after timeout", {31'b0, irq}, 1);

    csrWrite(5'h04, 0);
    pulseExt(3'b010, 32'h3B0, t); chk("R7 trig cause3", {27'b0, t}, 5'b01000);
    csrRead(5'h08, d); chk("R5 status two causes", d, 5'h09);
    csrRead(5'h08, d); chk("R9 status kept cor0", d, 5'h09);
    csrRead(5'h0C, d); chk("R8 first address kept", d, 32'h2A0);
    csrRead(5'h0C, d); chk("R9 addr kept cor1", d, 32'h2A0);
    csrWrite(5'h08, 0); csrWrite(5'h0C, 32'hFFFF);
    csrRead(5'h08, d); chk("R10 status write ignored", d, 5'h09);
    csrRead(5'h0C, d); chk("R10 addr write ignored", d, 32'h2A0);

    csrWrite(5'h04, 3);
    csrRead(5'h08, d); chk("R9 status pre-clear", d, 5'h09);
    csrRead(5'h08, d); chk("R9 status cleared", d, 0);
    csrRead(5'h0C, d); chk("R9 addr pre-clear", d, 32'h2A0);
    csrRead(5'h0C, d); chk("R9 addr cleared", d, 0);
    @(negedge clk); chk("R6 irq after clear", {31'b0, irq}, 0);

    csrWrite(5'h00, 32'h04);
    pulseExt(3'b001, 32'h500, t); chk("R7 trig masked cause2", {27'b0, t}, 5'b00100);
    chk("R6 irq masked", {31'b0, irq}, 0);
    csrRead(5'h08, d); chk("R5 masked cause latched", d, 5'h04);
    csrRead(5'h0C, d); chk("R8 addr with nothing pending", d, 32'h500);
    csrWrite(5'h00, 0);

    doXfer(1, 32'h900, 2, 1, n, e);
    chk("R11 endpoint err cycles", n, 2); chk("R11 endpoint err", {31'b0, e}, 1);
    csrRead(5'h08, d); chk("R5 endpoint cause", d, 5'h02);
    csrRead(5'h0C, d); chk("R8 endpoint addr", d, 32'h900);

    csrWrite(5'h10, 0);
    doXfer(1, 32'hA00, 40, 0, n, e);
    chk("R3 disabled cycles", n, 40); chk("R3 disabled err", {31'b0, e}, 0);
    csrRead(5'h08, d); chk("R3 no cause", d, 0);

    csrWrite(5'h10, 1);
    doXfer(1, 32'hB00, 10, 0, n, e);
    chk("R2 limit one cycle", n, 0); chk("R2 limit one err", {31'b0, e}, 1);
    csrRead(5'h08, d);

    csrWrite(5'h10, 6);
    doXfer(0, 32'hC00, 20, 0, n, e);
    chk("R4 read untimed", n, 20); chk("R4 read no err", {31'b0, e}, 0);
    doXfer(1, 32'hC04, 4, 0, n, e); chk("R4 first write", n, 4);
    doXfer(1, 32'hC08, 4, 0, n, e);
    chk("R4 restart count", n, 4); chk("R4 restart no err", {31'b0, e}, 0);

    @(posedge clk); #1 rstN = 0;
    repeat (2) @(posedge clk); #1 rstN = 1;
    doXfer(1, 32'hD00, 9000, 0, n, e);
    chk("R2 default limit cycle", n, 8191); chk("R2 default limit err", {31'b0, e}, 1);
    csrRead(5'h08, d); chk("R5 timeout cause", d, 5'h01);
    csrRead(5'h0C, d); chk("R8 timeout addr", d, 32'hD00);

    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule